// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Peripheral Pin Arbitration

This block is an 8-bit general-purpose I/O port. A CPU reaches two registers through a small register interface. The data register holds the values the port drives. The direction register chooses, pin by pin, whether the port drives the pin or only observes it. Two SPI units and two SCI units may each take pins away from the port. A fixed precedence decides which source owns each pin, and so which source supplies that pin's output value and output enable.

The upper nibble carries the second SPI unit's signals: bit 7 slave select, bit 6 clock, bit 5 MOSI, bit 4 MISO. The lower nibble carries the first SPI unit's signals in the same order on bits 3 to 0. The first SCI unit uses pins 1:0 and the second SCI unit uses pins 5:4. In both cases receive is on the lower bit and transmit on the upper bit.

Reads of the data register depend on direction. A bit whose direction bit is set returns the stored value. A bit configured as input returns the pin level after a synchronizer of `SYNC_STAGES` flops.

Each pin has an ownership state. `OWN_GPIO` is the state out of reset. A pin moves to `OWN_SPI_A`, `OWN_SPI_B`, `OWN_SCI_A` or `OWN_SCI_B` while the matching enable is high. It returns to `OWN_GPIO` as soon as no enabled unit claims it. These moves are combinational and are evaluated every cycle.

Top module: `gpio_pinmux_port`

## Requirements
- R1: Out of reset the data register and the direction register are all zero, and every `pad_oe` bit is 0.
- R2: A write with `reg_wr_en`=1 and `reg_addr`=0 loads the data register on the next clock edge. A read at `reg_addr`=0 returns the stored bit for each pin whose direction bit is 1.
- R3: A read at `reg_addr`=0 returns, for each pin whose direction bit is 0, the `pin_in` level. That level appears exactly `SYNC_STAGES` clock edges after the pin changes (default 2).
- R4: A write at `reg_addr`=1 loads the direction register on the next edge. A read at `reg_addr`=1 returns the direction register.
- R5: A pin that no enabled unit claims drives `pad_out` from its data bit and `pad_oe` from its direction bit.
- R6: While `spi_a_en`=1, pins 3:0 take `pad_out` and `pad_oe` from `spi_a_out` and `spi_a_oe`. Bit k of those vectors maps to pin k.
- R7: While `spi_b_en`=1, pins 7:4 take `pad_out` and `pad_oe` from `spi_b_out` and `spi_b_oe` (bit k to pin k+4). This holds even when `sci_b_en`=1.
- R8: While a unit owns its SCI pins, the receive pin has `pad_oe`=0 and `pad_out`=0, and the transmit pin has `pad_oe`=1 and `pad_out` equal to the unit's transmit input. The first unit uses pin 0 for receive and pin 1 for transmit. The second unit uses pin 4 for receive and pin 5 for transmit.
- R9: When `spi_a_en` and `sci_a_en` are both 1, pins 1:0 follow the first SPI unit.
- R10: A data-register write while a peripheral owns the pin still updates the stored bit. That bit drives the pin once the pin returns to GPIO use.
- R11: An enabled SCI unit claims only its own two pins. The other pins keep GPIO behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register select: 0 data, 1 direction |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Pad input levels |
| spi_a_en | input | 1 | First SPI unit enabled |
| spi_a_out | input | 4 | First SPI unit output values, pins 3:0 |
| spi_a_oe | input | 4 | First SPI unit output enables, pins 3:0 |
| spi_b_en | input | 1 | Second SPI unit enabled |
| spi_b_out | input | 4 | Second SPI unit output values, pins 7:4 |
| spi_b_oe | input | 4 | Second SPI unit output enables, pins 7:4 |
| sci_a_en | input | 1 | First SCI unit enabled |
| sci_a_tx | input | 1 | First SCI unit transmit value |
| sci_b_en | input | 1 | Second SCI unit enabled |
| sci_b_tx | input | 1 | Second SCI unit transmit value |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The hardest case to reach is a stored data value that is hidden behind a peripheral. It is written while an SPI unit owns the pin, so nothing shows at the pad at that time. It only becomes visible after the unit releases the pin.

The bench sets the direction to output and enables the first SPI unit with values that differ from the pending data. It then writes new data and checks that the pads still follow the SPI unit. Next it drops the enable and checks that the new data appears.

Layered precedence on a shared pin is reached the same way. Both the SPI and SCI enables for one nibble are raised together. The SPI unit is then removed, and the bench checks that the SCI pattern takes over.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;

    typedef enum logic [2:0] {
        OWN_GPIO  = 3'd0,
        OWN_SPI_A = 3'd1,
        OWN_SPI_B = 3'd2,
        OWN_SCI_A = 3'd3,
        OWN_SCI_B = 3'd4
    } pin_owner_e;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_DIR  = 1'b1;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pinmux_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_addr,
    input  logic              reg_wr_en,
    input  logic [PORT_W-1:0] reg_wdata,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] reg_rdata,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] dir_q
);

    logic wr_data_sel;
    logic wr_dir_sel;

    assign wr_data_sel = reg_wr_en && (reg_addr == ADDR_DATA);
    assign wr_dir_sel  = reg_wr_en && (reg_addr == ADDR_DIR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_data_sel) begin
            data_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_dir_sel) begin
            dir_q <= reg_wdata;
        end
    end

    // Output bits read back the stored value, input bits read the synchronized pad.
    always_comb begin
        unique case (reg_addr)
            ADDR_DATA: reg_rdata = (dir_q & data_q) | (~dir_q & pin_sync);
            ADDR_DIR:  reg_rdata = dir_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_input_sync.sv
module gpio_input_sync #(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_sync
);

    logic [PORT_W-1:0] stage_q [SYNC_STAGES];

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pin_sync = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/gpio_pin_arbiter.sv
module gpio_pin_arbiter
    import gpio_pinmux_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int SCI_A_RX = 0,
    parameter int SCI_B_RX = 4,
    localparam int HALF_W  = PORT_W / 2
) (
    input  logic              spi_a_en,
    input  logic [HALF_W-1:0] spi_a_out,
    input  logic [HALF_W-1:0] spi_a_oe,
    input  logic              spi_b_en,
    input  logic [HALF_W-1:0] spi_b_out,
    input  logic [HALF_W-1:0] spi_b_oe,
    input  logic              sci_a_en,
    input  logic              sci_a_tx,
    input  logic              sci_b_en,
    input  logic              sci_b_tx,
    input  logic [PORT_W-1:0] data_q,
    input  logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);

    pin_owner_e owner [PORT_W];

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        localparam bit IN_SCI_A = (i == SCI_A_RX) || (i == SCI_A_RX + 1);
        localparam bit IN_SCI_B = (i == SCI_B_RX) || (i == SCI_B_RX + 1);
        localparam bit IS_TX    = (i == SCI_A_RX + 1) || (i == SCI_B_RX + 1);

        logic spi_val;
        logic spi_ena;

        // Ownership state of this pin, by fixed precedence.
        if (i >= HALF_W) begin : g_upper
            assign spi_val = spi_b_out[i-HALF_W];
            assign spi_ena = spi_b_oe[i-HALF_W];
            always_comb begin
                if (spi_b_en)                 owner[i] = OWN_SPI_B;
                else if (sci_b_en && IN_SCI_B) owner[i] = OWN_SCI_B;
                else if (sci_a_en && IN_SCI_A) owner[i] = OWN_SCI_A;
                else                          owner[i] = OWN_GPIO;
            end
        end else begin : g_lower
            assign spi_val = spi_a_out[i];
            assign spi_ena = spi_a_oe[i];
            always_comb begin
                if (spi_a_en)                 owner[i] = OWN_SPI_A;
                else if (sci_a_en && IN_SCI_A) owner[i] = OWN_SCI_A;
                else if (sci_b_en && IN_SCI_B) owner[i] = OWN_SCI_B;
                else                          owner[i] = OWN_GPIO;
            end
        end

        // Pad drive selected by the ownership state.
        always_comb begin
            unique case (owner[i])
                OWN_SPI_A, OWN_SPI_B: begin
                    pad_out[i] = spi_val;
                    pad_oe[i]  = spi_ena;
                end
                OWN_SCI_A: begin
                    pad_out[i] = IS_TX ? sci_a_tx : 1'b0;
                    pad_oe[i]  = IS_TX;
                end
                OWN_SCI_B: begin
                    pad_out[i] = IS_TX ? sci_b_tx : 1'b0;
                    pad_oe[i]  = IS_TX;
                end
                default: begin
                    pad_out[i] = data_q[i];
                    pad_oe[i]  = dir_q[i];
                end
            endcase
        end
    end

endmodule

// File: rtl/gpio_pinmux_port.sv
module gpio_pinmux_port #(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int HALF_W     = PORT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_addr,
    input  logic              reg_wr_en,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic              spi_a_en,
    input  logic [HALF_W-1:0] spi_a_out,
    input  logic [HALF_W-1:0] spi_a_oe,
    input  logic              spi_b_en,
    input  logic [HALF_W-1:0] spi_b_out,
    input  logic [HALF_W-1:0] spi_b_oe,
    input  logic              sci_a_en,
    input  logic              sci_a_tx,
    input  logic              sci_b_en,
    input  logic              sci_b_tx,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);

    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] dir_q;

    gpio_input_sync #(
        .PORT_W      (PORT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_port_regs #(
        .PORT_W (PORT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .pin_sync  (pin_sync),
        .reg_rdata (reg_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q)
    );

    gpio_pin_arbiter #(
        .PORT_W   (PORT_W),
        .SCI_A_RX (0),
        .SCI_B_RX (HALF_W)
    ) u_arb (
        .spi_a_en  (spi_a_en),
        .spi_a_out (spi_a_out),
        .spi_a_oe  (spi_a_oe),
        .spi_b_en  (spi_b_en),
        .spi_b_out (spi_b_out),
        .spi_b_oe  (spi_b_oe),
        .sci_a_en  (sci_a_en),
        .sci_a_tx  (sci_a_tx),
        .sci_b_en  (sci_b_en),
        .sci_b_tx  (sci_b_tx),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

endmodule

// File: rtl/gpio_pinmux_port_chk.sv
module gpio_pinmux_port_chk #(
    parameter int PORT_W = 8,
    localparam int HALF_W = PORT_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_addr,
    input logic              reg_wr_en,
    input logic [PORT_W-1:0] reg_wdata,
    input logic              spi_a_en,
    input logic [HALF_W-1:0] spi_a_out,
    input logic [HALF_W-1:0] spi_a_oe,
    input logic              spi_b_en,
    input logic [HALF_W-1:0] spi_b_out,
    input logic [HALF_W-1:0] spi_b_oe,
    input logic              sci_a_en,
    input logic              sci_a_tx,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] data_q,
    input logic [PORT_W-1:0] dir_q
);

    p_data_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 1'b0) |=> (data_q == $past(reg_wdata)));

    p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 1'b1) |=> (dir_q == $past(reg_wdata)));

    p_spi_a_owns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_a_en |-> (pad_out[HALF_W-1:0] == spi_a_out && pad_oe[HALF_W-1:0] == spi_a_oe));

    p_spi_b_owns_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_b_en |-> (pad_out[PORT_W-1:HALF_W] == spi_b_out && pad_oe[PORT_W-1:HALF_W] == spi_b_oe));

    p_sci_a_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_a_en && !spi_a_en) |-> (!pad_oe[0] && pad_oe[1] && pad_out[1] == sci_a_tx));

    p_idle_gpio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_a_en && !sci_a_en) |-> (pad_oe[HALF_W-1:2] == dir_q[HALF_W-1:2]
                                      && pad_out[HALF_W-1:0] == data_q[HALF_W-1:0]
                                      && pad_oe[1:0] == dir_q[1:0]));

endmodule

bind gpio_pinmux_port gpio_pinmux_port_chk #(.PORT_W(PORT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .spi_a_en  (spi_a_en),
    .spi_a_out (spi_a_out),
    .spi_a_oe  (spi_a_oe),
    .spi_b_en  (spi_b_en),
    .spi_b_out (spi_b_out),
    .spi_b_oe  (spi_b_oe),
    .sci_a_en  (sci_a_en),
    .sci_a_tx  (sci_a_tx),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .data_q    (data_q),
    .dir_q     (dir_q)
);

// File: tb/tb_gpio_pinmux_port.sv
`timescale 1ns/1ps
module tb_gpio_pinmux_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = '0;
    logic       spi_a_en = 1'b0;
    logic [3:0] spi_a_out = '0;
    logic [3:0] spi_a_oe = '0;
    logic       spi_b_en = 1'b0;
    logic [3:0] spi_b_out = '0;
    logic [3:0] spi_b_oe = '0;
    logic       sci_a_en = 1'b0;
    logic       sci_a_tx = 1'b0;
    logic       sci_b_en = 1'b0;
    logic       sci_b_tx = 1'b0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    gpio_pinmux_port dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .spi_a_en(spi_a_en), .spi_a_out(spi_a_out), .spi_a_oe(spi_a_oe),
        .spi_b_en(spi_b_en), .spi_b_out(spi_b_out), .spi_b_oe(spi_b_oe),
        .sci_a_en(sci_a_en), .sci_a_tx(sci_a_tx), .sci_b_en(sci_b_en),
        .sci_b_tx(sci_b_tx), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic addr, input logic [7:0] val);
        @(negedge clk);
        reg_addr = addr; reg_wdata = val; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic addr, output logic [7:0] val);
        reg_addr = addr;
        #0.5;
        val = reg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(1'b1, v); chk("R1", "dir after reset", v, 8'h00);
        wr_reg(1'b1, 8'hFF);
        rd_reg(1'b0, v); chk("R1", "data after reset", v, 8'h00);
        wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_reset_pads();
        chk("R1", "pad_oe after reset", pad_oe, 8'h00);
    endtask

    task automatic t_dir_rw();
        logic [7:0] v;
        wr_reg(1'b1, 8'h5A);
        rd_reg(1'b1, v); chk("R4", "dir readback", v, 8'h5A);
        wr_reg(1'b1, 8'hFF);
        rd_reg(1'b1, v); chk("R4", "dir readback ff", v, 8'hFF);
    endtask

    task automatic t_data_rw();
        logic [7:0] v;
        wr_reg(1'b1, 8'hFF);
        wr_reg(1'b0, 8'hC3);
        rd_reg(1'b0, v); chk("R2", "data readback", v, 8'hC3);
        wr_reg(1'b0, 8'h3C);
        rd_reg(1'b0, v); chk("R2", "data readback 2", v, 8'h3C);
    endtask

    task automatic t_input_sync();
        logic [7:0] v;
        wr_reg(1'b1, 8'hF0);
        wr_reg(1'b0, 8'hA5);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'h0F;
        @(posedge clk); @(negedge clk);
        rd_reg(1'b0, v); chk("R3", "one edge after pin change", v, 8'hA0);
        @(posedge clk); @(negedge clk);
        rd_reg(1'b0, v); chk("R3", "two edges after pin change", v, 8'hAF);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_gpio_drive();
        wr_reg(1'b1, 8'h96);
        wr_reg(1'b0, 8'h6C);
        #0.5;
        chk("R5", "gpio pad_oe", pad_oe, 8'h96);
        chk("R5", "gpio pad_out", pad_out, 8'h6C);
    endtask

    task automatic t_spi_a();
        wr_reg(1'b1, 8'hFF);
        wr_reg(1'b0, 8'h00);
        spi_a_out = 4'b1010; spi_a_oe = 4'b0111; spi_a_en = 1'b1;
        #0.5;
        chk("R6", "spi_a pad_out", pad_out, 8'h0A);
        chk("R6", "spi_a pad_oe", pad_oe, 8'hF7);
        spi_a_en = 1'b0;
    endtask

    task automatic t_spi_b_over_sci_b();
        wr_reg(1'b1, 8'h00);
        wr_reg(1'b0, 8'h00);
        sci_b_en = 1'b1; sci_b_tx = 1'b1;
        spi_b_out = 4'b0101; spi_b_oe = 4'b1001; spi_b_en = 1'b1;
        #0.5;
        chk("R7", "spi_b over sci_b pad_out", pad_out, 8'h50);
        chk("R7", "spi_b over sci_b pad_oe", pad_oe, 8'h90);
        spi_b_en = 1'b0;
        #0.5;
        chk("R8", "sci_b pad_oe", pad_oe, 8'h20);
        chk("R8", "sci_b pad_out", pad_out, 8'h20);
        sci_b_en = 1'b0; sci_b_tx = 1'b0;
    endtask

    task automatic t_sci_a_and_partial();
        wr_reg(1'b1, 8'hFF);
        wr_reg(1'b0, 8'hFF);
        sci_a_en = 1'b1; sci_a_tx = 1'b0;
        #0.5;
        chk("R8", "sci_a pad_oe", pad_oe, 8'hFE);
        chk("R8", "sci_a pad_out tx low", pad_out, 8'hFC);
        sci_a_tx = 1'b1;
        #0.5;
        chk("R11", "other pins stay gpio", pad_out, 8'hFE);
        spi_a_en = 1'b1; spi_a_out = 4'b0001; spi_a_oe = 4'b0001;
        #0.5;
        chk("R9", "spi_a over sci_a pad_oe", pad_oe, 8'hF1);
        chk("R9", "spi_a over sci_a pad_out", pad_out, 8'hF1);
        spi_a_en = 1'b0; sci_a_en = 1'b0; sci_a_tx = 1'b0;
    endtask

    task automatic t_write_while_owned();
        wr_reg(1'b1, 8'hFF);
        wr_reg(1'b0, 8'h00);
        spi_a_en = 1'b1; spi_a_out = 4'b0000; spi_a_oe = 4'b1111;
        wr_reg(1'b0, 8'h0F);
        #0.5;
        chk("R10", "owned pins ignore new data", pad_out, 8'h00);
        spi_a_en = 1'b0;
        #0.5;
        chk("R10", "stored data drives after release", pad_out, 8'h0F);
    endtask

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pads();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_rw();
        t_data_rw();
        t_input_sync();
        t_gpio_drive();
        t_spi_a();
        t_spi_b_over_sci_b();
        t_sci_a_and_partial();
        t_write_while_owned();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule